// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block receives serial data that arrives with a separate bit clock and no start or stop bits. Eight data bits, least significant first, are shifted in on rising edges of the serial clock. Once a frame is complete it is handed to a data register, and a full flag is raised. The serial clock comes from one of two sources. It can be produced inside the block by dividing the system clock, and is then driven out on a pin. It can also be taken from a pin and brought into the system clock domain through a synchronizer.

A host reaches the block through a small register port. The port has a control register with enable, interrupt-enable and clock-source bits, a status register, a read-only data register and a divide-ratio register. The host clears a status flag by writing 0 to its bit.

If a frame finishes while the previous one is still unread, the block records an overrun. The old data and the full flag are kept. Reception then stops until the host clears the flags.

Top module: `sync_rx_port`

## Requirements
- R1: In external-clock mode (control bit 2 = 1), eight bits sampled on rising edges of `sck_in` form one frame, with the first bit landing in data bit 0. When the frame completes and the full flag (status bit 0) is 0, the frame is copied to the data register (address 2) and the full flag is set.
- R2: `sck_oe` is 0 in external-clock mode and 1 in internal-clock mode (control bit 2 = 0).
- R3: In internal-clock mode the block drives `sck_out`. While reception is running (enabled and no overrun), each level of `sck_out` lasts divide-ratio + 1 system clocks, where the divide ratio is held at address 3 and resets to 3. While reception is not running, `sck_out` idles at 1. Frames are sampled on its rising edges.
- R4: `irq_rx` equals the full flag ANDed with the interrupt enable (control bit 1).
- R5: A frame that completes while the full flag is 1 sets the overrun flag (status bit 1). It leaves both the data register and the full flag unchanged.
- R6: `irq_err` equals the overrun flag ANDed with the interrupt enable.
- R7: While the overrun flag is 1, no bits are sampled and `sck_out` stays at 1. After the host writes 0 to both flags, reception resumes and the next frame is stored normally.
- R8: Writing 0 to a status bit clears that flag, and writing 1 has no effect. If a frame completes in the same cycle as a clear, the clear is dropped and the frame's effect wins.
- R9: Clearing the enable (control bit 0) discards a partly received frame, so the next frame starts from bit 0. The data register and the flags are left unchanged.
- R10: After reset, the control, status and data registers read 0, the divide ratio reads 3, both interrupt outputs are 0 and `sck_out` is 1.
- R11: Frames arriving back to back are all delivered without overrun, provided the host reads the data and clears the full flag between frame completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 divide ratio |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internally generated serial clock |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| sdata_in | input | 1 | Serial data |
| irq_rx | output | 1 | Receive-data interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
A host write that clears the full flag can reach the status register in the same system clock as the completion of a frame. The bench provokes this in external-clock mode. It counts the synchronizer stages from the last rising edge of `sck_in`, so that the clearing write lands exactly on the completion cycle while the full flag is still 1. The expected result is that the frame wins: the overrun flag rises, the full flag stays 1 and the older data is kept. The behavioural model predicts this, and it is judged both through the status register and through `irq_err` on every clock.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_DIV  = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_IE_BIT  = 1;
  localparam int CTRL_EXT_BIT = 2;
  localparam int STAT_FULL_BIT = 0;
  localparam int STAT_OVR_BIT  = 1;

  typedef struct packed {
    logic ext;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/srx_rst_sync.sv
module srx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/srx_clk_unit.sv
module srx_clk_unit #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic             active,
  input  logic [DIV_W-1:0] div,
  input  logic             sck_in,
  input  logic             sdata_in,
  output logic             sck_out,
  output logic             sck_oe,
  output logic             sample,
  output logic             din
);
  // external path: synchronizer plus one extra stage for edge detection
  logic [SYNC_STAGES:0]   sck_sh_q;
  logic [SYNC_STAGES-1:0] dat_sh_q;
  logic                   ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sh_q <= '0;
      dat_sh_q <= '0;
    end else begin
      sck_sh_q <= {sck_sh_q[SYNC_STAGES-1:0], sck_in};
      dat_sh_q <= {dat_sh_q[SYNC_STAGES-2:0], sdata_in};
    end
  end

  assign ext_rise = sck_sh_q[SYNC_STAGES-1] & ~sck_sh_q[SYNC_STAGES];
  assign din      = dat_sh_q[SYNC_STAGES-1];

  // internal path: half-period counter and clock level
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             run_int, wrap, int_rise;

  assign run_int  = active & ~ext_mode;
  assign wrap     = (cnt_q == div);
  assign int_rise = run_int & wrap & ~sck_q;

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run_int) begin
      cnt_d = '0;
      sck_d = 1'b1;
    end else if (wrap) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck_out = sck_q;
  assign sck_oe  = ~ext_mode;
  assign sample  = ext_mode ? (ext_rise & active) : int_rise;
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sample,
  input  logic              din,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_word
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              last;

  assign last       = (cnt_q == LAST_IDX);
  assign frame_word = {din, sr_q[DATA_W-1:1]};
  assign frame_done = sample & last & ~clr;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clr) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (sample) begin
      sr_d  = frame_word;
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/srx_regs.sv
module srx_regs
  import srx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_word,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic [DIV_W-1:0]  div,
  output logic              full,
  output logic              ovr,
  output logic [DATA_W-1:0] data
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              full_q, full_d, ovr_q, ovr_d;
  logic [DATA_W-1:0] data_q;
  logic              data_en;
  logic              wr_ctrl, wr_stat, wr_div;

  assign wr_ctrl = wr & (addr == SEL_CTRL);
  assign wr_stat = wr & (addr == SEL_STAT);
  assign wr_div  = wr & (addr == SEL_DIV);

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    if (wr_ctrl) begin
      ctrl_d.en  = wdata[CTRL_EN_BIT];
      ctrl_d.ie  = wdata[CTRL_IE_BIT];
      ctrl_d.ext = wdata[CTRL_EXT_BIT];
    end
    if (wr_div) div_d = wdata[DIV_W-1:0];
  end

  always_comb begin
    full_d  = full_q;
    ovr_d   = ovr_q;
    data_en = 1'b0;
    if (frame_done) begin
      if (full_q) ovr_d = 1'b1;
      else begin
        full_d  = 1'b1;
        data_en = 1'b1;
      end
    end else if (wr_stat) begin
      if (!wdata[STAT_FULL_BIT]) full_d = 1'b0;
      if (!wdata[STAT_OVR_BIT])  ovr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= DIV_W'(DIV_RESET);
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= frame_word;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      SEL_CTRL: begin
        rdata[CTRL_EN_BIT]  = ctrl_q.en;
        rdata[CTRL_IE_BIT]  = ctrl_q.ie;
        rdata[CTRL_EXT_BIT] = ctrl_q.ext;
      end
      SEL_STAT: begin
        rdata[STAT_FULL_BIT] = full_q;
        rdata[STAT_OVR_BIT]  = ovr_q;
      end
      SEL_DATA: rdata = data_q;
      SEL_DIV:  rdata[DIV_W-1:0] = div_q;
      default:  rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign div  = div_q;
  assign full = full_q;
  assign ovr  = ovr_q;
  assign data = data_q;
endmodule

// File: rtl/sync_rx_port.sv
module sync_rx_port
  import srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int DIV_RESET   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              sdata_in,
  output logic              irq_rx,
  output logic              irq_err
);
  logic              rst_sync_n;
  ctrl_t             ctrl;
  logic [DIV_W-1:0]  div;
  logic              full_q, ovr_q;
  logic [DATA_W-1:0] data_q;
  logic              rx_en, rx_ie, ext_mode, rx_active;
  logic              sample_pulse, din_s;
  logic              frame_done;
  logic [DATA_W-1:0] frame_word;

  srx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign rx_en     = ctrl.en;
  assign rx_ie     = ctrl.ie;
  assign ext_mode  = ctrl.ext;
  assign rx_active = rx_en & ~ovr_q;

  srx_clk_unit #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst_n(rst_sync_n), .ext_mode(ext_mode), .active(rx_active),
    .div(div), .sck_in(sck_in), .sdata_in(sdata_in), .sck_out(sck_out),
    .sck_oe(sck_oe), .sample(sample_pulse), .din(din_s)
  );

  srx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .clr(~rx_en), .sample(sample_pulse),
    .din(din_s), .frame_done(frame_done), .frame_word(frame_word)
  );

  srx_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .frame_done(frame_done), .frame_word(frame_word),
    .rdata(reg_rdata), .ctrl(ctrl), .div(div), .full(full_q), .ovr(ovr_q),
    .data(data_q)
  );

  assign irq_rx  = full_q & rx_ie;
  assign irq_err = ovr_q & rx_ie;
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              rx_ie,
  input logic              active,
  input logic              ext_mode,
  input logic              sample,
  input logic              frame_done,
  input logic              full,
  input logic              ovr,
  input logic [DATA_W-1:0] data,
  input logic              sck_out,
  input logic              irq_rx,
  input logic              irq_err
);
  AST_FULL_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(frame_done)); // R1
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !ext_mode) |=> sck_out); // R3
  AST_IRQ_RX_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (full && rx_ie)); // R4
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($stable(data) && full)); // R5
  AST_IRQ_ERR_ON_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovr) && rx_ie) |-> irq_err); // R6
  AST_HALT_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> !sample); // R7
  AST_FRAME_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> full); // R8
  AST_DISABLED_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !frame_done); // R9
endmodule

bind sync_rx_port srx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rx_en(rx_en), .rx_ie(rx_ie),
  .active(rx_active), .ext_mode(ext_mode), .sample(sample_pulse),
  .frame_done(frame_done), .full(full_q), .ovr(ovr_q), .data(data_q),
  .sck_out(sck_out), .irq_rx(irq_rx), .irq_err(irq_err)
);

// File: tb/sync_rx_port_test.sv
module sync_rx_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sck_in = 1'b0;
  logic       sck_out, sck_oe;
  logic       sdata_in = 1'b0;
  logic       irq_rx, irq_err;

  int checks = 0;
  int errors = 0;
  bit settle = 1'b1;
  bit done_run = 1'b0;

  // behavioural model of the host-visible state
  bit       m_full = 0, m_ovr = 0, m_ie = 0;
  bit [7:0] m_data = 0;

  always #2.5 clk = ~clk;

  sync_rx_port uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdata_in(sdata_in),
    .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the interrupt outputs against the model
  always @(negedge clk) begin
    if (!settle && !done_run) begin
      chk("R4 irq_rx vs model", irq_rx, m_full & m_ie);
      chk("R6 irq_err vs model", irq_err, m_ovr & m_ie);
    end
  end

  function automatic void model_frame(input bit [7:0] w);
    if (m_ovr) return;
    if (m_full) m_ovr = 1;
    else begin m_full = 1; m_data = w; end
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    if (a == 2'd1) begin
      if (!d[0]) m_full = 0;
      if (!d[1]) m_ovr = 0;
    end
    if (a == 2'd0) m_ie = d[1];
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(posedge clk); #1;
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic ext_bit(input bit b);
    @(posedge clk); #1;
    sck_in = 1'b0; sdata_in = b;
    repeat (4) @(posedge clk);
    #1 sck_in = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic ext_frame(input bit [7:0] w);
    settle = 1;
    for (int i = 0; i < 8; i++) ext_bit(w[i]);
    #1 sck_in = 1'b0;
    model_frame(w);
    settle = 0;
  endtask

  task automatic wait_rise(output int n);
    logic p;
    n = 0;
    p = sck_out;
    forever begin
      @(negedge clk);
      n++;
      if (!p && sck_out) break;
      p = sck_out;
    end
  endtask

  task automatic int_frame(input bit [7:0] w);
    int n;
    settle = 1;
    for (int i = 0; i < 8; i++) begin
      sdata_in = w[i];
      wait_rise(n);
    end
    model_frame(w);
    settle = 0;
  endtask

  initial begin
    int n;
    bit idle_ok;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R10 reset state
    rd_chk("R10 ctrl after reset", 2'd0, 8'h00);
    rd_chk("R10 status after reset", 2'd1, 8'h00);
    rd_chk("R10 data after reset", 2'd2, 8'h00);
    rd_chk("R10 divide after reset", 2'd3, 8'h03);
    chk("R10 irq_rx after reset", irq_rx, 0);
    chk("R10 irq_err after reset", irq_err, 0);
    chk("R10 sck_out idle after reset", sck_out, 1);
    settle = 0;

    // external clock mode: en | ie | ext
    wr_reg(2'd0, 8'h07);
    chk("R2 sck_oe low in external mode", sck_oe, 0);
    ext_frame(8'hA5);
    rd_chk("R1 data of first frame", 2'd2, 8'hA5);
    rd_chk("R1 full set", 2'd1, 8'h01);
    chk("R4 irq_rx raised", irq_rx, 1);

    // R8 write 1 has no effect, write 0 clears
    wr_reg(2'd1, 8'h03);
    rd_chk("R8 write one keeps flags", 2'd1, 8'h01);
    wr_reg(2'd1, 8'h00);
    rd_chk("R8 write zero clears full", 2'd1, 8'h00);

    // R11 back-to-back with service between frames
    ext_frame(8'h3C);
    rd_chk("R11 first of pair", 2'd2, 8'h3C);
    wr_reg(2'd1, 8'h00);
    ext_frame(8'hC3);
    rd_chk("R11 second of pair", 2'd2, 8'hC3);
    rd_chk("R11 no overrun", 2'd1, 8'h01);
    wr_reg(2'd1, 8'h00);

    // R5/R6 overrun
    ext_frame(8'h11);
    ext_frame(8'h22);
    rd_chk("R5 data kept on overrun", 2'd2, 8'h11);
    rd_chk("R5 full and overrun set", 2'd1, 8'h03);
    chk("R6 irq_err raised", irq_err, 1);

    // R7 halted while overrun set
    ext_frame(8'h44);
    rd_chk("R7 halted frame not stored", 2'd2, 8'h11);
    wr_reg(2'd1, 8'h00);
    ext_frame(8'h55);
    rd_chk("R7 resumed frame stored", 2'd2, 8'h55);
    rd_chk("R7 resumed flags", 2'd1, 8'h01);

    // R8 clear of full colliding with frame completion (full=1, data 0x55)
    settle = 1;
    for (int i = 0; i < 7; i++) ext_bit(1'b1);
    @(posedge clk); #1;
    sck_in = 1'b0; sdata_in = 1'b0;
    repeat (4) @(posedge clk);
    #1 sck_in = 1'b1;
    @(posedge clk);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h00;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    repeat (3) @(posedge clk);
    #1 sck_in = 1'b0;
    m_ovr = 1;
    settle = 0;
    rd_chk("R8 frame wins over clear", 2'd1, 8'h03);
    rd_chk("R8 data kept in collision", 2'd2, 8'h55);
    wr_reg(2'd1, 8'h00);

    // R9 disable mid-frame
    ext_frame(8'h81);
    settle = 1;
    for (int i = 0; i < 3; i++) ext_bit(1'b1);
    #1 sck_in = 1'b0;
    settle = 0;
    wr_reg(2'd0, 8'h06);
    rd_chk("R9 flags kept on disable", 2'd1, 8'h01);
    rd_chk("R9 data kept on disable", 2'd2, 8'h81);
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd0, 8'h07);
    ext_frame(8'h5A);
    rd_chk("R9 partial frame discarded", 2'd2, 8'h5A);
    wr_reg(2'd1, 8'h00);

    // R3 internal clock mode
    wr_reg(2'd0, 8'h03);
    chk("R2 sck_oe high in internal mode", sck_oe, 1);
    wait_rise(n);
    wait_rise(n);
    chk("R3 period is twice (div+1)", n, 8);
    wr_reg(2'd0, 8'h02);
    idle_ok = 1;
    repeat (20) begin @(negedge clk); if (sck_out !== 1'b1) idle_ok = 0; end
    chk("R3 sck_out idle when disabled", idle_ok, 1);
    sdata_in = 1'b0;
    wr_reg(2'd0, 8'h03);
    int_frame(8'h96);
    rd_chk("R3 internal frame stored", 2'd2, 8'h96);
    int_frame(8'h69);
    rd_chk("R5 internal overrun flags", 2'd1, 8'h03);
    idle_ok = 1;
    repeat (30) begin @(negedge clk); if (sck_out !== 1'b1) idle_ok = 0; end
    chk("R7 clock stopped while halted", idle_ok, 1);
    rd_chk("R5 internal data kept", 2'd2, 8'h96);

    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done_run) begin
      done_run = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule